// File: doc/BRIEF.md
# Priority Address Range Decoder

This block steers one memory access at a time to one of a set of target regions. Each region is held in a slot that stores an inclusive lower and upper address bound and a valid flag. A request carries an address, a size in bits, a write enable and write data. The decoder works out the last byte the access touches and compares the whole span against every valid slot. When regions overlap, the slot that was mapped most recently wins.

The winning slot is returned as a one-hot select together with an offset relative to that region's lower bound. A byte strobe is derived from the access size, and the write data is masked to match it. When no slot covers the whole span, an error pulse is raised in place of the access.

Slots are loaded through a configuration port. A single write either maps a slot with new bounds, which makes it the newest slot, or unmaps it. The decode result is registered, so outputs appear one clock after the request.

Top module: `addr_range_decoder`

## Requirements
- R1: A valid slot matches a request only if the request address is at or above the slot's lower bound and the last byte (address plus span in bytes minus one) is at or below the slot's upper bound. Both bounds are inclusive.
- R2: The span in bytes follows from `req_size`: 8 gives 1 byte, 16 gives 2 bytes, and any other value gives the full data word (DATA_W/8 bytes).
- R3: When several valid slots match, the one mapped most recently is selected. `tgt_sel` is one-hot with bit i meaning slot i.
- R4: `tgt_offset` equals the request address minus the lower bound of the selected slot.
- R5: A request that no slot matches raises `err_bad_addr` for one cycle, and `tgt_valid` stays low.
- R6: If the last byte of the span would wrap past the top of the address space, no slot matches.
- R7: A map command whose upper bound is below its lower bound is ignored. The slot keeps its previous bounds, its valid state and its priority.
- R8: An unmap command (`cfg_map` = 0) clears the slot's valid flag, so the slot no longer matches.
- R9: `tgt_be` is 4'b0001 for size 8, 4'b0011 for size 16 and all ones otherwise (bit b enables byte b, little-endian). `tgt_wdata` passes the bytes that are enabled and zeroes the rest, and `tgt_we` copies `req_we`.
- R10: Outputs are registered. A request in cycle n gives exactly one of `tgt_valid` or `err_bad_addr` in cycle n+1, and a cycle without a request gives neither.
- R11: After reset all slots are invalid and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | SLOT_W | Slot index to configure |
| cfg_map | input | 1 | 1 = map with bounds, 0 = unmap |
| cfg_start | input | ADDR_W | Inclusive lower bound |
| cfg_end | input | ADDR_W | Inclusive upper bound |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request byte address |
| req_size | input | 8 | Access size in bits |
| req_we | input | 1 | Request is a write |
| req_wdata | input | DATA_W | Write data |
| tgt_valid | output | 1 | Forwarded access this cycle |
| tgt_sel | output | NUM_SLOTS | One-hot selected slot |
| tgt_offset | output | ADDR_W | Region-relative address |
| tgt_we | output | 1 | Forwarded write enable |
| tgt_be | output | DATA_W/8 | Byte strobe |
| tgt_wdata | output | DATA_W | Masked write data |
| err_bad_addr | output | 1 | No region covers the access |

## Verification
The bench builds the decoder with ADDR_W = 16 and NUM_SLOTS = 4, keeping DATA_W = 32. With a 16-bit address space, spans that wrap past 0xFFFF can be reached with directed requests. Four slots scattered over a few kilobytes overlap often, so random traffic regularly reaches the case where priority must be resolved among two or more matching slots. Random remaps, unmaps and illegal maps then shuffle the slot ordering that the bench's model tracks by map time.

// File: rtl/adec_pkg.sv
package adec_pkg;

   localparam int SIZE_W = 8;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } size_cls_e;

   function automatic size_cls_e classify_size(input logic [SIZE_W-1:0] sz);
      if (sz == SIZE_W'(8))       return SZ_BYTE;
      else if (sz == SIZE_W'(16)) return SZ_HALF;
      else                        return SZ_WORD;
   endfunction

endpackage

// File: rtl/adec_slot_table.sv
module adec_slot_table #(
   parameter int ADDR_W    = 32,
   parameter int NUM_SLOTS = 8,
   parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                cfg_we,
   input  logic [SLOT_W-1:0]                   cfg_slot,
   input  logic                                cfg_map,
   input  logic [ADDR_W-1:0]                   cfg_start,
   input  logic [ADDR_W-1:0]                   cfg_end,
   output logic [NUM_SLOTS-1:0]                slot_vld,
   output logic [NUM_SLOTS-1:0][ADDR_W-1:0]    slot_lo,
   output logic [NUM_SLOTS-1:0][ADDR_W-1:0]    slot_hi,
   output logic [NUM_SLOTS-1:0][SLOT_W-1:0]    slot_rank
);

   localparam logic [SLOT_W-1:0] TOP_RANK = SLOT_W'(NUM_SLOTS - 1);

   logic slot_in_range;
   logic bounds_ok;
   logic do_map;
   logic do_unmap;

   assign slot_in_range = (int'(cfg_slot) < NUM_SLOTS);
   assign bounds_ok     = (cfg_start <= cfg_end);
   assign do_map        = cfg_we && cfg_map && bounds_ok && slot_in_range;
   assign do_unmap      = cfg_we && !cfg_map && slot_in_range;

   // Ranks form a permutation; a freshly mapped slot moves to the top and
   // those that were above it step down by one.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_vld <= '0;
         for (int i = 0; i < NUM_SLOTS; i++) begin
            slot_lo[i]   <= '0;
            slot_hi[i]   <= '0;
            slot_rank[i] <= SLOT_W'(i);
         end
      end else if (do_map) begin
         slot_vld[cfg_slot] <= 1'b1;
         slot_lo[cfg_slot]  <= cfg_start;
         slot_hi[cfg_slot]  <= cfg_end;
         for (int i = 0; i < NUM_SLOTS; i++) begin
            if (SLOT_W'(i) == cfg_slot)
               slot_rank[i] <= TOP_RANK;
            else if (slot_rank[i] > slot_rank[cfg_slot])
               slot_rank[i] <= slot_rank[i] - 1'b1;
         end
      end else if (do_unmap) begin
         slot_vld[cfg_slot] <= 1'b0;
      end
   end

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot_chk
      // R3: a mapped slot becomes the newest
      a_r3_newest_on_map: assert property (@(posedge clk) disable iff (!rst_n)
         (do_map && cfg_slot == SLOT_W'(g)) |=> (slot_rank[g] == TOP_RANK && slot_vld[g]));
      // R7: an inverted map leaves the slot untouched
      a_r7_inverted_ignored: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_map && !bounds_ok && cfg_slot == SLOT_W'(g))
         |=> ($stable(slot_lo[g]) && $stable(slot_hi[g]) && $stable(slot_vld[g])
              && $stable(slot_rank[g])));
      // R8: unmap clears the valid flag
      a_r8_unmap_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (do_unmap && cfg_slot == SLOT_W'(g)) |=> !slot_vld[g]);
   end

endmodule

// File: rtl/adec_match.sv
module adec_match #(
   parameter int ADDR_W    = 32,
   parameter int NUM_SLOTS = 8
) (
   input  logic [NUM_SLOTS-1:0]                slot_vld,
   input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]    slot_lo,
   input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]    slot_hi,
   input  logic [ADDR_W-1:0]                   req_addr,
   input  logic [ADDR_W:0]                     req_last_x,
   output logic [NUM_SLOTS-1:0]                hit
);

   logic              wraps;
   logic [ADDR_W-1:0] req_last;

   assign wraps    = req_last_x[ADDR_W];
   assign req_last = req_last_x[ADDR_W-1:0];

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
      assign hit[g] = slot_vld[g] && !wraps
                      && (req_addr >= slot_lo[g])
                      && (req_last <= slot_hi[g]);
   end

endmodule

// File: rtl/adec_pick.sv
module adec_pick #(
   parameter int NUM_SLOTS = 8,
   parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic [NUM_SLOTS-1:0]                hit,
   input  logic [NUM_SLOTS-1:0][SLOT_W-1:0]    rank,
   output logic                                any_hit,
   output logic [SLOT_W-1:0]                   win_idx,
   output logic [NUM_SLOTS-1:0]                win_onehot
);

   logic [SLOT_W-1:0] best_rank;

   always_comb begin
      any_hit   = 1'b0;
      win_idx   = '0;
      best_rank = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (hit[i] && (!any_hit || rank[i] > best_rank)) begin
            any_hit   = 1'b1;
            win_idx   = SLOT_W'(i);
            best_rank = rank[i];
         end
      end
   end

   always_comb begin
      win_onehot = '0;
      if (any_hit) win_onehot[win_idx] = 1'b1;
   end

endmodule

// File: rtl/addr_range_decoder.sv
module addr_range_decoder #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int NUM_SLOTS = 8,
   parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [SLOT_W-1:0]          cfg_slot,
   input  logic                       cfg_map,
   input  logic [ADDR_W-1:0]          cfg_start,
   input  logic [ADDR_W-1:0]          cfg_end,
   input  logic                       req_valid,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [7:0]                 req_size,
   input  logic                       req_we,
   input  logic [DATA_W-1:0]          req_wdata,
   output logic                       tgt_valid,
   output logic [NUM_SLOTS-1:0]       tgt_sel,
   output logic [ADDR_W-1:0]          tgt_offset,
   output logic                       tgt_we,
   output logic [DATA_W/8-1:0]        tgt_be,
   output logic [DATA_W-1:0]          tgt_wdata,
   output logic                       err_bad_addr
);
   import adec_pkg::*;

   localparam int BYTES = DATA_W / 8;

   // elaboration-time parameter checks
   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data_w
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("NUM_SLOTS must be at least 2");
   end
   if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_addr_w
      $error("ADDR_W out of supported range");
   end
   if ((1 << SLOT_W) < NUM_SLOTS) begin : g_bad_slot_w
      $error("SLOT_W too narrow for NUM_SLOTS");
   end

   logic [NUM_SLOTS-1:0]             slot_vld;
   logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_lo;
   logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_hi;
   logic [NUM_SLOTS-1:0][SLOT_W-1:0] slot_rank;

   adec_slot_table #(
      .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_map(cfg_map),
      .cfg_start(cfg_start), .cfg_end(cfg_end),
      .slot_vld(slot_vld), .slot_lo(slot_lo), .slot_hi(slot_hi),
      .slot_rank(slot_rank)
   );

   // access span from size
   size_cls_e          size_cls;
   logic [ADDR_W:0]    span_m1;
   logic [ADDR_W:0]    req_last_x;
   logic [BYTES-1:0]   be_c;
   logic [DATA_W-1:0]  wdata_c;

   assign size_cls = classify_size(req_size);

   always_comb begin
      unique case (size_cls)
         SZ_BYTE: begin span_m1 = '0;                      be_c = BYTES'(1); end
         SZ_HALF: begin span_m1 = (ADDR_W+1)'(1);          be_c = BYTES'(3); end
         default: begin span_m1 = (ADDR_W+1)'(BYTES - 1);  be_c = '1;        end
      endcase
   end

   assign req_last_x = {1'b0, req_addr} + span_m1;

   for (genvar b = 0; b < BYTES; b++) begin : g_mask
      assign wdata_c[8*b +: 8] = be_c[b] ? req_wdata[8*b +: 8] : 8'h00;
   end

   logic [NUM_SLOTS-1:0] hit;

   adec_match #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_match (
      .slot_vld(slot_vld), .slot_lo(slot_lo), .slot_hi(slot_hi),
      .req_addr(req_addr), .req_last_x(req_last_x), .hit(hit)
   );

   logic                 any_hit;
   logic [SLOT_W-1:0]    win_idx;
   logic [NUM_SLOTS-1:0] win_onehot;

   adec_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_pick (
      .hit(hit), .rank(slot_rank),
      .any_hit(any_hit), .win_idx(win_idx), .win_onehot(win_onehot)
   );

   logic [ADDR_W-1:0] offset_c;
   assign offset_c = req_addr - slot_lo[win_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_valid    <= 1'b0;
         err_bad_addr <= 1'b0;
         tgt_sel      <= '0;
         tgt_offset   <= '0;
         tgt_we       <= 1'b0;
         tgt_be       <= '0;
         tgt_wdata    <= '0;
      end else begin
         tgt_valid    <= req_valid && any_hit;
         err_bad_addr <= req_valid && !any_hit;
         if (req_valid && any_hit) begin
            tgt_sel    <= win_onehot;
            tgt_offset <= offset_c;
            tgt_we     <= req_we;
            tgt_be     <= be_c;
            tgt_wdata  <= wdata_c;
         end else begin
            tgt_sel    <= '0;
            tgt_we     <= 1'b0;
            tgt_be     <= '0;
         end
      end
   end

   // R10: one response per request, one cycle later
   a_r10_one_response: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (tgt_valid ^ err_bad_addr));
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!tgt_valid && !err_bad_addr));
   // R5: error and access never together
   a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(tgt_valid && err_bad_addr));
   // R3: a forwarded access selects exactly one slot
   a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_valid |-> $onehot(tgt_sel));
   // R9: strobe is a contiguous run from byte 0
   a_r9_be_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_valid |-> (tgt_be[0] && ((tgt_be & (tgt_be + 1'b1)) == '0)));
   // R6: a wrapping span never reaches a target
   a_r6_wrap_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_last_x[ADDR_W]) |=> err_bad_addr);

endmodule

// File: tb/addr_range_decoder_tb.sv
module addr_range_decoder_tb;

   localparam int ADDR_W    = 16;
   localparam int DATA_W    = 32;
   localparam int NUM_SLOTS = 4;
   localparam int SLOT_W    = 2;
   localparam int BYTES     = DATA_W / 8;
   localparam time CLK_PERIOD = 10ns;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 cfg_we = 1'b0;
   logic [SLOT_W-1:0]    cfg_slot = '0;
   logic                 cfg_map = 1'b0;
   logic [ADDR_W-1:0]    cfg_start = '0;
   logic [ADDR_W-1:0]    cfg_end = '0;
   logic                 req_valid = 1'b0;
   logic [ADDR_W-1:0]    req_addr = '0;
   logic [7:0]           req_size = '0;
   logic                 req_we = 1'b0;
   logic [DATA_W-1:0]    req_wdata = '0;
   logic                 tgt_valid;
   logic [NUM_SLOTS-1:0] tgt_sel;
   logic [ADDR_W-1:0]    tgt_offset;
   logic                 tgt_we;
   logic [BYTES-1:0]     tgt_be;
   logic [DATA_W-1:0]    tgt_wdata;
   logic                 err_bad_addr;

   addr_range_decoder #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_map(cfg_map),
      .cfg_start(cfg_start), .cfg_end(cfg_end),
      .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
      .req_we(req_we), .req_wdata(req_wdata),
      .tgt_valid(tgt_valid), .tgt_sel(tgt_sel), .tgt_offset(tgt_offset),
      .tgt_we(tgt_we), .tgt_be(tgt_be), .tgt_wdata(tgt_wdata),
      .err_bad_addr(err_bad_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // reference model
   bit m_vld [NUM_SLOTS];
   int m_lo  [NUM_SLOTS];
   int m_hi  [NUM_SLOTS];
   int m_age [NUM_SLOTS];
   int age_ctr = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int span_of(input int sz);
      if (sz == 8)  return 1;
      if (sz == 16) return 2;
      return BYTES;
   endfunction

   // returns winning slot or -1
   function automatic int model_pick(input int addr, input int sz);
      int last = addr + span_of(sz) - 1;
      int best = -1;
      if (last > (1 << ADDR_W) - 1) return -1;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (m_vld[i] && addr >= m_lo[i] && last <= m_hi[i])
            if (best < 0 || m_age[i] > m_age[best]) best = i;
      end
      return best;
   endfunction

   task automatic do_cfg(input int slot, input bit map, input int lo, input int hi);
      @(negedge clk);
      cfg_we = 1'b1; cfg_slot = SLOT_W'(slot); cfg_map = map;
      cfg_start = ADDR_W'(lo); cfg_end = ADDR_W'(hi);
      @(negedge clk);
      cfg_we = 1'b0;
      if (!map) m_vld[slot] = 1'b0;
      else if (lo <= hi) begin
         m_vld[slot] = 1'b1; m_lo[slot] = lo; m_hi[slot] = hi;
         age_ctr++; m_age[slot] = age_ctr;
      end
   endtask

   task automatic do_req(input int addr, input int sz, input bit we,
                         input logic [DATA_W-1:0] wd, input string tag);
      int w;
      logic [BYTES-1:0]  exp_be;
      logic [DATA_W-1:0] exp_wd;
      @(negedge clk);
      req_valid = 1'b1; req_addr = ADDR_W'(addr); req_size = 8'(sz);
      req_we = we; req_wdata = wd;
      w = model_pick(addr, sz);
      exp_be = (span_of(sz) == 1) ? BYTES'(1) : (span_of(sz) == 2) ? BYTES'(3) : '1;
      for (int b = 0; b < BYTES; b++)
         exp_wd[8*b +: 8] = exp_be[b] ? wd[8*b +: 8] : 8'h00;
      @(negedge clk);
      req_valid = 1'b0;
      if (w < 0) begin
         chk(err_bad_addr && !tgt_valid, {tag, " R5 err"},
             {err_bad_addr, tgt_valid}, 2'b10);
      end else begin
         chk(tgt_valid && !err_bad_addr, {tag, " R1 hit"},
             {tgt_valid, err_bad_addr}, 2'b10);
         chk(tgt_sel == NUM_SLOTS'(1 << w), {tag, " R3 sel"}, tgt_sel, 1 << w);
         chk(tgt_offset == ADDR_W'(addr - m_lo[w]), {tag, " R4 offset"},
             tgt_offset, addr - m_lo[w]);
         chk(tgt_be == exp_be, {tag, " R9 be"}, tgt_be, exp_be);
         chk(tgt_wdata == exp_wd && tgt_we == we, {tag, " R9 wdata"}, tgt_wdata, exp_wd);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      for (int i = 0; i < NUM_SLOTS; i++) begin
         m_vld[i] = 1'b0; m_lo[i] = 0; m_hi[i] = 0; m_age[i] = 0;
      end
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(!tgt_valid && !err_bad_addr && tgt_sel == '0 && tgt_be == '0,
          "R11 reset outputs", {tgt_valid, err_bad_addr, tgt_sel}, 0);
      rst_n = 1'b1;
      do_req(16'h0000, 8, 1'b0, '0, "R11 empty table");

      // R1, R2: inclusive bounds, span by size
      do_cfg(0, 1'b1, 16'h0100, 16'h01FF);
      do_req(16'h0100, 8,  1'b1, 32'hA1B2C3D4, "R1 lower edge");
      do_req(16'h01FE, 16, 1'b1, 32'hA1B2C3D4, "R2 half at top");
      do_req(16'h01FE, 32, 1'b1, 32'hA1B2C3D4, "R2 word spills");
      do_req(16'h01FF, 8,  1'b0, 32'h11223344, "R1 upper edge");
      do_req(16'h00FF, 8,  1'b0, '0, "R1 below lo");
      do_req(16'h01FC, 7,  1'b1, 32'hDEADBEEF, "R2 odd size word");

      // R3: overlap, newest wins, then re-map reorders
      do_cfg(1, 1'b1, 16'h0180, 16'h02FF);
      do_req(16'h0190, 32, 1'b0, '0, "R3 newer slot1");
      do_cfg(0, 1'b1, 16'h0100, 16'h01FF);
      do_req(16'h0190, 32, 1'b0, '0, "R3 remapped slot0");

      // R7: inverted map ignored, slot1 keeps bounds and rank
      do_cfg(1, 1'b1, 16'h0500, 16'h0400);
      do_req(16'h0250, 16, 1'b1, 32'h0000BEEF, "R7 slot1 kept");
      do_req(16'h0190, 8,  1'b0, '0, "R7 rank kept");
      do_req(16'h0450, 8,  1'b0, '0, "R7 no new range");

      // R8: unmap
      do_cfg(1, 1'b0, 0, 0);
      do_req(16'h0250, 8, 1'b0, '0, "R8 unmapped");

      // R6: wrap past the top
      do_cfg(2, 1'b1, 16'hFF00, 16'hFFFF);
      do_req(16'hFFFE, 32, 1'b1, 32'h12345678, "R6 wrap");
      do_req(16'hFFFC, 32, 1'b1, 32'h12345678, "R6 last word");
      do_req(16'hFFFF, 16, 1'b0, '0, "R6 half wrap");

      // R10: idle cycle produces nothing
      @(negedge clk);
      @(negedge clk);
      chk(!tgt_valid && !err_bad_addr, "R10 idle",
          {tgt_valid, err_bad_addr}, 0);

      // random mix
      for (int it = 0; it < 600; it++) begin
         if ($urandom_range(0, 4) == 0) begin
            int lo = $urandom_range(0, 4095);
            int hi = lo + $urandom_range(0, 1500);
            int sl = $urandom_range(0, NUM_SLOTS-1);
            case ($urandom_range(0, 5))
               0:       do_cfg(sl, 1'b0, 0, 0);
               1:       do_cfg(sl, 1'b1, hi, (lo > 0) ? lo - 1 : 0);
               default: do_cfg(sl, 1'b1, lo, hi);
            endcase
         end else begin
            int sz;
            case ($urandom_range(0, 3))
               0: sz = 8;
               1: sz = 16;
               2: sz = 32;
               default: sz = $urandom_range(0, 255);
            endcase
            do_req($urandom_range(0, 6000), sz, 1'($urandom_range(0, 1)),
                   $urandom, "R3 random");
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule